// File: doc/BRIEF.md
# Cross-Parity Protected Register File

This block is an eight-entry, eight-bit register file that guards its own contents against transient bit flips. Next to the data it holds three check vectors. The row vector has one parity bit for each register. The column vector has one parity bit for each bit position, taken over all registers. The diagonal vector has one parity bit for each wrapped diagonal of the register-by-bit matrix. A write stores fresh check vectors. On every cycle the block recomputes all three vectors from the live contents and compares them with the stored copies. The three differences form the syndrome, which is driven out unchanged.

The block reads the syndrome as a logic pattern. If exactly one row, exactly one column and the diagonal through their crossing all disagree, one bit has flipped. The block raises a correctable flag and restores that bit at the next clock edge. Any other non-zero pattern raises only the error flag and leaves the contents alone, for whatever sits above the block to handle. A flip input models radiation or coupling upsets, so that the detection and repair paths can be exercised.

Top module: `xpar_regfile`

## Requirements
- R1: While reset is held, and in the first cycle after it, every register reads zero, both flags are low and all three syndrome vectors are zero.
- R2: A write at a clock edge is visible on both combinational read ports in the cycle that follows. The read ports always show the raw stored contents, including a flip that has not been repaired yet.
- R3: A write leaves no false alarm. In the cycle after any write with no flip injected, the error flag is low, even when writes arrive on back-to-back cycles.
- R4: Bit (8*r + c) of `upset_map` flips bit c of register r at a clock edge. After a single flip, in the following cycle `err_flag` and `err_correctable` are both 1, `row_syndrome` has only bit r set, `col_syndrome` has only bit c set and `diag_syndrome` has only bit ((r + c) mod 8) set.
- R5: A correctable error is repaired at the next clock edge. After that edge the register reads its value from before the flip and both flags are low.
- R6: Two flips in one register give `err_flag` = 1, `err_correctable` = 0, a zero row syndrome and a column syndrome with two bits set. With no write and no further flip, the flags, the syndromes and the contents then stay unchanged.
- R7: Flips in two different registers and columns give `err_flag` = 1 and `err_correctable` = 0, with two bits set in both the row syndrome and the column syndrome.
- R8: A write recomputes all three stored vectors from the contents that result from it, so it clears a standing uncorrectable syndrome.
- R9: A flip injected at the same edge as a write to the same register lands on the newly written data. It is reported as correctable, and at the next edge it is repaired back to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register index to write |
| wr_data | input | 8 | Data to write |
| rd_addr_a | input | 3 | Read port A index |
| rd_data_a | output | 8 | Read port A data, combinational |
| rd_addr_b | input | 3 | Read port B index |
| rd_data_b | output | 8 | Read port B data, combinational |
| upset_map | input | 64 | Flip injection; bit 8*r+c flips bit c of register r |
| err_flag | output | 1 | Any syndrome bit set |
| err_correctable | output | 1 | Syndrome locates exactly one flipped bit |
| row_syndrome | output | 8 | Bit r: register r fails its row parity |
| col_syndrome | output | 8 | Bit c: bit position c fails its column parity |
| diag_syndrome | output | 8 | Bit d: diagonal d fails its parity |

## Verification
Writes and flips take effect at the clock edge they are driven into, and every result is combinational from registered state. Read data, flags and syndromes are therefore due in the cycle directly after the stimulus edge. A repair lands one edge later, so the clean result is due two cycles after the flip. The driver drives each stimulus on a falling edge and queues the outcome that its own contents-and-baseline model predicts for the next rising edge. The monitor pops exactly one item per cycle, 2 ns after that rising edge, so every comparison is made against state that has already settled.

// File: rtl/xpar_pkg.sv
package xpar_pkg;
  localparam int XP_NREG  = 8;
  localparam int XP_WIDTH = 8;
  localparam int XP_AW    = $clog2(XP_NREG);
  localparam int XP_BW    = $clog2(XP_WIDTH);

  typedef logic [XP_WIDTH-1:0] xp_word_t;
  typedef logic [XP_NREG-1:0][XP_WIDTH-1:0] xp_file_t;

  typedef struct packed {
    logic [XP_NREG-1:0]  row;
    logic [XP_WIDTH-1:0] col;
    logic [XP_WIDTH-1:0] diag;
  } xp_chk_t;

  // wrapped diagonal that cell (r, c) belongs to
  function automatic int xp_diag_idx(input int r, input int c);
    return (r + c) % XP_WIDTH;
  endfunction

  // full cross-parity encoding of the register file
  function automatic xp_chk_t xp_encode(input xp_file_t f);
    xp_chk_t e;
    e = '0;
    for (int r = 0; r < XP_NREG; r++) begin
      for (int c = 0; c < XP_WIDTH; c++) begin
        e.row[r]                 ^= f[r][c];
        e.col[c]                 ^= f[r][c];
        e.diag[xp_diag_idx(r, c)] ^= f[r][c];
      end
    end
    return e;
  endfunction

  function automatic logic [XP_AW-1:0] xp_row_pos(input logic [XP_NREG-1:0] v);
    logic [XP_AW-1:0] p;
    p = '0;
    for (int i = 0; i < XP_NREG; i++) begin
      if (v[i]) p = XP_AW'(i);
    end
    return p;
  endfunction

  function automatic logic [XP_BW-1:0] xp_col_pos(input logic [XP_WIDTH-1:0] v);
    logic [XP_BW-1:0] p;
    p = '0;
    for (int i = 0; i < XP_WIDTH; i++) begin
      if (v[i]) p = XP_BW'(i);
    end
    return p;
  endfunction
endpackage

// File: rtl/xpar_gen.sv
module xpar_gen
  import xpar_pkg::*;
(
  input  xp_file_t file_i,
  output xp_chk_t  chk_o
);
  assign chk_o = xp_encode(file_i);
endmodule

// File: rtl/xpar_diag.sv
module xpar_diag
  import xpar_pkg::*;
(
  input  xp_chk_t           stored_i,
  input  xp_chk_t           live_i,
  output xp_chk_t           syn_o,
  output logic              err_o,
  output logic              fix_o,
  output logic [XP_AW-1:0]  fix_reg_o,
  output logic [XP_BW-1:0]  fix_bit_o
);
  logic                one_row;
  logic                one_col;
  logic                diag_hit;
  logic [XP_WIDTH-1:0] diag_expect;

  always_comb begin
    syn_o       = stored_i ^ live_i;
    err_o       = |syn_o;
    fix_reg_o   = xp_row_pos(syn_o.row);
    fix_bit_o   = xp_col_pos(syn_o.col);
    one_row     = $onehot(syn_o.row);
    one_col     = $onehot(syn_o.col);
    diag_expect = '0;
    diag_expect[xp_diag_idx(int'(fix_reg_o), int'(fix_bit_o))] = 1'b1;
    diag_hit    = (syn_o.diag == diag_expect);
    fix_o       = one_row & one_col & diag_hit;
  end
endmodule

// File: rtl/xpar_store.sv
module xpar_store
  import xpar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [XP_AW-1:0]  wr_addr,
  input  xp_word_t          wr_data,
  input  logic              fix_en,
  input  logic [XP_AW-1:0]  fix_reg,
  input  logic [XP_BW-1:0]  fix_bit,
  input  xp_file_t          upset_map,
  input  xp_chk_t           chk_next,
  output xp_file_t          file_q,
  output xp_file_t          clean_next,
  output xp_chk_t           chk_q
);
  // repair first, then the write, so a write to the faulty register wins
  always_comb begin
    clean_next = file_q;
    if (fix_en) clean_next[fix_reg][fix_bit] = ~file_q[fix_reg][fix_bit];
    if (wr_en)  clean_next[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      file_q <= '0;
      chk_q  <= '0;
    end else begin
      file_q <= clean_next ^ upset_map;
      if (wr_en) chk_q <= chk_next;
    end
  end
endmodule

// File: rtl/xpar_regfile.sv
module xpar_regfile
  import xpar_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [XP_AW-1:0]              wr_addr,
  input  logic [XP_WIDTH-1:0]           wr_data,
  input  logic [XP_AW-1:0]              rd_addr_a,
  output logic [XP_WIDTH-1:0]           rd_data_a,
  input  logic [XP_AW-1:0]              rd_addr_b,
  output logic [XP_WIDTH-1:0]           rd_data_b,
  input  logic [XP_NREG*XP_WIDTH-1:0]   upset_map,
  output logic                          err_flag,
  output logic                          err_correctable,
  output logic [XP_NREG-1:0]            row_syndrome,
  output logic [XP_WIDTH-1:0]           col_syndrome,
  output logic [XP_WIDTH-1:0]           diag_syndrome
);
  xp_file_t          file_q;
  xp_file_t          clean_next;
  xp_file_t          upset_file;
  xp_chk_t           chk_q;
  xp_chk_t           chk_live;
  xp_chk_t           chk_next;
  xp_chk_t           syn;
  logic              fix_en;
  logic [XP_AW-1:0]  fix_reg;
  logic [XP_BW-1:0]  fix_bit;

  assign upset_file = upset_map;

  xpar_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .fix_en     (fix_en),
    .fix_reg    (fix_reg),
    .fix_bit    (fix_bit),
    .upset_map  (upset_file),
    .chk_next   (chk_next),
    .file_q     (file_q),
    .clean_next (clean_next),
    .chk_q      (chk_q)
  );

  // live encoder checks the stored file; next encoder prepares a write
  xpar_gen u_gen_live (.file_i(file_q),     .chk_o(chk_live));
  xpar_gen u_gen_next (.file_i(clean_next), .chk_o(chk_next));

  xpar_diag u_diag (
    .stored_i  (chk_q),
    .live_i    (chk_live),
    .syn_o     (syn),
    .err_o     (err_flag),
    .fix_o     (fix_en),
    .fix_reg_o (fix_reg),
    .fix_bit_o (fix_bit)
  );

  assign err_correctable = fix_en;
  assign row_syndrome    = syn.row;
  assign col_syndrome    = syn.col;
  assign diag_syndrome   = syn.diag;
  assign rd_data_a       = file_q[rd_addr_a];
  assign rd_data_b       = file_q[rd_addr_b];
endmodule

// File: rtl/xpar_regfile_chk.sv
module xpar_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [63:0] upset_map,
  input logic        err_flag,
  input logic        err_correctable,
  input logic [7:0]  row_syndrome,
  input logic [7:0]  col_syndrome,
  input logic [7:0]  diag_syndrome
);
  // R1: reset leaves a quiet syndrome
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n |=> (!err_flag && row_syndrome == '0 && col_syndrome == '0));

  // R3: a clean write never raises an alarm in the next cycle
  a_r3_no_false_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(upset_map) == '0) |-> !err_flag);

  // R4: a correctable report always points at one row, one column, one diagonal
  a_r4_single_locate: assert property (@(posedge clk) disable iff (!rst_n)
    err_correctable |-> (err_flag && $onehot(row_syndrome) && $onehot(col_syndrome)
                         && $countones(diag_syndrome) == 1));

  // R5: repair clears the error one edge later
  a_r5_repair_next: assert property (@(posedge clk) disable iff (!rst_n)
    (err_correctable && upset_map == '0) |=> !err_flag);

  // R6: an uncorrectable error is held untouched when nothing else happens
  a_r6_hold_uncorr: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_correctable && !wr_en && upset_map == '0) |=>
      (err_flag && !err_correctable && $stable(row_syndrome)
       && $stable(col_syndrome) && $stable(diag_syndrome)));
endmodule

bind xpar_regfile xpar_regfile_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_en           (wr_en),
  .upset_map       (upset_map),
  .err_flag        (err_flag),
  .err_correctable (err_correctable),
  .row_syndrome    (row_syndrome),
  .col_syndrome    (col_syndrome),
  .diag_syndrome   (diag_syndrome)
);

// File: tb/xpar_regfile_tb.sv
module xpar_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr_a = '0;
  logic [2:0]  rd_addr_b = '0;
  logic [63:0] upset_map = '0;
  logic [7:0]  rd_data_a, rd_data_b;
  logic        err_flag, err_correctable;
  logic [7:0]  row_syndrome, col_syndrome, diag_syndrome;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xpar_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .upset_map(upset_map), .err_flag(err_flag), .err_correctable(err_correctable),
    .row_syndrome(row_syndrome), .col_syndrome(col_syndrome), .diag_syndrome(diag_syndrome)
  );

  typedef struct {
    string      tag;
    logic [7:0] a, b;
    logic       err, cor;
    logic [7:0] row, col, diag;
  } exp_t;
  exp_t q[$];

  // model: actual contents and the contents the check vectors were taken from
  logic [7:0] m_cur [8];
  logic [7:0] m_base[8];
  logic [7:0] s_row, s_col, s_diag;
  logic       s_err, s_cor;
  int         s_r, s_c;

  task automatic model_syndrome();
    s_row = '0; s_col = '0; s_diag = '0;
    for (int r = 0; r < 8; r++) begin
      logic [7:0] d;
      d = m_cur[r] ^ m_base[r];
      for (int c = 0; c < 8; c++) begin
        if (d[c]) begin
          s_row[r] = ~s_row[r];
          s_col[c] = ~s_col[c];
          s_diag[(r + c) & 7] = ~s_diag[(r + c) & 7];
        end
      end
    end
    s_err = (s_row != 0) || (s_col != 0) || (s_diag != 0);
    s_r = -1; s_c = -1;
    for (int i = 0; i < 8; i++) begin
      if (s_row == (8'd1 << i)) s_r = i;
      if (s_col == (8'd1 << i)) s_c = i;
    end
    s_cor = (s_r >= 0) && (s_c >= 0) && (s_diag == (8'd1 << ((s_r + s_c) & 7)));
  endtask

  task automatic drive(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                       input logic [63:0] up, input logic [2:0] ra, input logic [2:0] rb,
                       input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; upset_map = up;
    rd_addr_a = ra; rd_addr_b = rb;
    model_syndrome();
    if (s_cor) m_cur[s_r][s_c] = ~m_cur[s_r][s_c];
    if (we) begin
      m_cur[wa] = wd;
      for (int r = 0; r < 8; r++) m_base[r] = m_cur[r];
    end
    for (int r = 0; r < 8; r++) m_cur[r] = m_cur[r] ^ up[r*8 +: 8];
    model_syndrome();
    e.tag = tag; e.a = m_cur[ra]; e.b = m_cur[rb];
    e.err = s_err; e.cor = s_cor; e.row = s_row; e.col = s_col; e.diag = s_diag;
    q.push_back(e);
  endtask

  task automatic idle(input logic [2:0] ra, input logic [2:0] rb, input string tag);
    drive(1'b0, 3'd0, 8'h00, 64'h0, ra, rb, tag);
  endtask

  function automatic logic [63:0] flip(input int r, input int c);
    return 64'h1 << (r * 8 + c);
  endfunction

  // monitor: one expected item per cycle, sampled after the edge has settled
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (rd_data_a !== e.a || rd_data_b !== e.b || err_flag !== e.err ||
            err_correctable !== e.cor || row_syndrome !== e.row ||
            col_syndrome !== e.col || diag_syndrome !== e.diag) begin
          n_fail++;
          $display("FAIL %s: actual a=%h b=%h err=%b cor=%b row=%h col=%h diag=%h expected a=%h b=%h err=%b cor=%b row=%h col=%h diag=%h",
                   e.tag, rd_data_a, rd_data_b, err_flag, err_correctable, row_syndrome,
                   col_syndrome, diag_syndrome, e.a, e.b, e.err, e.cor, e.row, e.col, e.diag);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual not done, expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) begin m_cur[r] = '0; m_base[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3'd0, 3'd7, "R1 reset state");
    // R2/R3: back-to-back writes, read back on both ports
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 3'(i), 8'(8'h3C ^ (i * 8'h25)), 64'h0, 3'(i), 3'((i + 7) % 8),
            "R2 R3 write and read back");
    end
    idle(3'd5, 3'd2, "R2 read both ports");
    // R4/R5: single flip, then repair
    drive(1'b0, 3'd0, 8'h00, flip(3, 4), 3'd3, 3'd0, "R4 single flip reg3 bit4");
    idle(3'd3, 3'd0, "R5 repaired reg3");
    drive(1'b0, 3'd0, 8'h00, flip(6, 5), 3'd6, 3'd1, "R4 single flip wrapped diagonal");
    idle(3'd6, 3'd1, "R5 repaired reg6");
    // R6: two flips in one register, held untouched
    drive(1'b0, 3'd0, 8'h00, flip(2, 0) | flip(2, 1), 3'd2, 3'd3, "R6 double flip same register");
    idle(3'd2, 3'd3, "R6 held untouched");
    idle(3'd2, 3'd4, "R6 held untouched again");
    // R8: a write rebaselines
    drive(1'b1, 3'd2, 8'hA5, 64'h0, 3'd2, 3'd1, "R8 write clears standing error");
    // R7: flips in two registers
    drive(1'b0, 3'd0, 8'h00, flip(1, 7) | flip(5, 2), 3'd1, 3'd5, "R7 flips in two registers");
    idle(3'd1, 3'd5, "R7 still uncorrectable");
    drive(1'b1, 3'd0, 8'h11, 64'h0, 3'd1, 3'd5, "R8 write clears two-register error");
    // R9: write and flip on the same register at the same edge
    drive(1'b1, 3'd4, 8'h5A, flip(4, 6), 3'd4, 3'd0, "R9 flip lands on new data");
    idle(3'd4, 3'd0, "R9 repaired to written value");
    // R5: repair while another register is written
    drive(1'b0, 3'd0, 8'h00, flip(0, 0), 3'd0, 3'd7, "R4 single flip reg0 bit0");
    drive(1'b1, 3'd7, 8'hC3, 64'h0, 3'd0, 3'd7, "R5 repair alongside write");
    idle(3'd0, 3'd7, "R3 quiet after repair and write");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule